// File: doc/BRIEF.md
# Four-State Hard-Decision Viterbi Decoder

This block recovers the information bits of a rate-1/2 convolutional code with two memory bits (four encoder states) from hard-decision received symbols. One 2-bit symbol is taken per clock while the input valid is high. Four add-compare-select elements, one for each encoder state, update all four path metrics in the same cycle and write one column of survivor decisions per symbol.

Once a fixed window of 7 symbols has been collected, a traceback walks the survivor columns from the newest to the oldest. It takes one cycle per column and stores the recovered bits. The bits then leave oldest-first as a 7-cycle burst, with a flag on the last bit. Each window is decoded on its own, starting from a known all-zero encoder state. While traceback and output are in progress the block reports busy and ignores any symbols offered.

Top module: `viterbi4_dec`

## Requirements
- R1: The code is defined as follows. The encoder state is s = {s1,s0}. For input bit b, the received symbol is sym[1] = b^s1^s0 and sym[0] = b^s0, and the next state is {b,s1}. An error-free window of 7 symbols, produced from state 0, decodes to exactly the 7 encoded bits.
- R2: The branch metric is the Hamming distance (0..2) between the received symbol and the symbol a transition would produce. A window with a single flipped bit in any of symbols 0..5 still decodes to the encoded bits.
- R3: Each state's new metric is the smaller of its two predecessor-plus-branch sums. Metrics are 4 bits wide and saturate at 15 instead of wrapping. Within a window, the smallest metric over all states never decreases from one stage to the next.
- R4: A symbol is taken only in a cycle where symValid is high and busy is low. Idle cycles between the symbols of a window do not change the result.
- R5: At the first symbol of every window, the metrics restart with state 0 at 0 and the other states at 15. A window decodes correctly whatever the previous window left behind.
- R6: Traceback starts from the state with the smallest final metric. On a tie, the lowest state number wins. Example: the bits 0,0,0,0,0,0,1 with bit 0 of the last symbol flipped decode as seven zeros.
- R7: busy is high from the cycle after the 7th symbol is taken. outValid first rises 7 cycles after busy rises.
- R8: The 7 decoded bits appear on outBit on 7 consecutive outValid cycles, oldest first. frameDone is high only together with the 7th bit.
- R9: busy falls in the cycle after the last bit is output. Symbols offered while busy is high have no effect on the decoded output.
- R10: After reset, outValid, frameDone and busy are low, and a window that was partly collected before reset is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| symValid | input | 1 | Received symbol present on sym |
| sym | input | 2 | Hard-decision received symbol |
| busy | output | 1 | Traceback or output in progress, input ignored |
| outValid | output | 1 | outBit holds a decoded bit |
| outBit | output | 1 | Decoded bit, oldest of the window first |
| frameDone | output | 1 | Marks the last decoded bit of a window |

## Verification
The bench targets several corner cases.

A single bit error that leaves two final states with equal metrics tests the lowest-state rule. A decoder that broke the tie the other way would return a 1 in the last position.

A clean window that follows an all-ones window would start from a stale state if the per-window metric restart were missing.

The bench also offers symbols during busy. A decoder that still took them would corrupt the next window's survivors, or start collecting early.

Finally, the bench measures the exact cycle at which output starts and where frameDone falls in the burst, and it pulses reset in the middle of a window. A lost cycle in the traceback count or a stale symbol counter shows up as wrong bits or a shifted burst.

// File: rtl/v4_pkg.sv
package v4_pkg;
  localparam int WIN_LEN = 7;                 // symbols per decoding window
  localparam int PM_W    = 4;                 // path metric width
  localparam int NUM_ST  = 4;                 // encoder states
  localparam int IDX_W   = $clog2(WIN_LEN);   // stage index width

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic             acsEn;    // update metrics and write one survivor column
    logic             useInit;  // first stage: start from known zero state
    logic             tbEn;     // traceback step
    logic             tbFirst;  // first traceback step: start from best state
    logic [IDX_W-1:0] col;      // survivor column to write or read
    logic [IDX_W-1:0] outSel;   // decoded bit to present
  } dp_ctrl_t;
endpackage

// File: rtl/v4_acs_pe.sv
module v4_acs_pe #(
  parameter int PM_W   = 4,
  parameter int ST_ID  = 0
) (
  input  logic [PM_W-1:0] pmLo,   // metric of predecessor {n0,0}
  input  logic [PM_W-1:0] pmHi,   // metric of predecessor {n0,1}
  input  logic [1:0]      sym,
  output logic [PM_W-1:0] pmNew,
  output logic            decBit
);
  localparam logic [1:0] ST = ST_ID[1:0];
  localparam logic [PM_W-1:0] PM_MAX = {PM_W{1'b1}};
  // branch labels: input bit is ST[1], predecessor low bit is the decision
  localparam logic [1:0] EXP_LO = {ST[1] ^ ST[0], ST[1]};
  localparam logic [1:0] EXP_HI = {~(ST[1] ^ ST[0]), ~ST[1]};

  logic [1:0] diffLo, diffHi;
  logic [1:0] bmLo, bmHi;
  logic [PM_W:0] sumLo, sumHi;
  logic [PM_W-1:0] candLo, candHi;

  always_comb begin
    diffLo = sym ^ EXP_LO;
    diffHi = sym ^ EXP_HI;
    bmLo   = {1'b0, diffLo[1]} + {1'b0, diffLo[0]};
    bmHi   = {1'b0, diffHi[1]} + {1'b0, diffHi[0]};
    sumLo  = {1'b0, pmLo} + {{(PM_W-1){1'b0}}, bmLo};
    sumHi  = {1'b0, pmHi} + {{(PM_W-1){1'b0}}, bmHi};
    candLo = sumLo[PM_W] ? PM_MAX : sumLo[PM_W-1:0];
    candHi = sumHi[PM_W] ? PM_MAX : sumHi[PM_W-1:0];
    decBit = (candHi < candLo);
    pmNew  = decBit ? candHi : candLo;
  end
endmodule

// File: rtl/v4_ctrl.sv
module v4_ctrl
  import v4_pkg::*;
#(
  parameter int WIN = WIN_LEN
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     symValid,
  output dp_ctrl_t ctl,
  output logic     busy,
  output logic     outValid,
  output logic     frameDone
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(WIN - 1);

  typedef enum logic [1:0] {COLLECT, TRACE, DRAIN} phase_t;
  phase_t phase;
  logic [IDX_W-1:0] cnt;

  always_comb begin
    ctl = '0;
    ctl.col = cnt;
    ctl.outSel = cnt;
    unique case (phase)
      COLLECT: begin
        ctl.acsEn   = symValid;
        ctl.useInit = (cnt == '0);
      end
      TRACE: begin
        ctl.tbEn    = 1'b1;
        ctl.tbFirst = (cnt == LAST);
      end
      default: ;
    endcase
  end

  assign busy      = (phase != COLLECT);
  assign outValid  = (phase == DRAIN);
  assign frameDone = (phase == DRAIN) && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= COLLECT;
      cnt   <= '0;
    end else begin
      unique case (phase)
        COLLECT: if (symValid) begin
          if (cnt == LAST) phase <= TRACE;   // cnt stays at the newest column
          else cnt <= cnt + 1'b1;
        end
        TRACE: begin
          if (cnt == '0) phase <= DRAIN;
          else cnt <= cnt - 1'b1;
        end
        default: begin
          if (cnt == LAST) begin
            phase <= COLLECT;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/v4_dp.sv
module v4_dp
  import v4_pkg::*;
#(
  parameter int WIN = WIN_LEN,
  parameter int PMW = PM_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  dp_ctrl_t   ctl,
  input  logic [1:0] sym,
  output logic       outBit
);
  localparam logic [PMW-1:0] PM_MAX = {PMW{1'b1}};

  logic [PMW-1:0] pmQ   [NUM_ST];
  logic [PMW-1:0] pmOld [NUM_ST];
  logic [PMW-1:0] pmNew [NUM_ST];
  logic [NUM_ST-1:0] decVec;
  logic [WIN-1:0][NUM_ST-1:0] surv;
  logic [WIN-1:0] bitBuf;
  logic [1:0] tbSt, curSt, bestSt;
  logic [PMW-1:0] bestPm;
  logic [NUM_ST*PMW-1:0] pmFlat;   // observed by the checker

  // known all-zero start at the first stage of every window
  always_comb begin
    for (int i = 0; i < NUM_ST; i++) begin
      pmOld[i] = ctl.useInit ? ((i == 0) ? '0 : PM_MAX) : pmQ[i];
      pmFlat[i*PMW +: PMW] = pmQ[i];
    end
  end

  for (genvar n = 0; n < NUM_ST; n++) begin : g_pe
    localparam int PRED = (n % 2) * 2;  // predecessor {n0,0}
    v4_acs_pe #(.PM_W(PMW), .ST_ID(n)) u_pe (
      .pmLo  (pmOld[PRED]),
      .pmHi  (pmOld[PRED + 1]),
      .sym   (sym),
      .pmNew (pmNew[n]),
      .decBit(decVec[n])
    );
  end

  // best final state, lowest number on ties
  always_comb begin
    bestSt = 2'd0;
    bestPm = pmQ[0];
    for (int i = 1; i < NUM_ST; i++) begin
      if (pmQ[i] < bestPm) begin
        bestPm = pmQ[i];
        bestSt = 2'(i);
      end
    end
    curSt = ctl.tbFirst ? bestSt : tbSt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ST; i++) pmQ[i] <= (i == 0) ? '0 : PM_MAX;
      surv   <= '0;
      bitBuf <= '0;
      tbSt   <= '0;
    end else begin
      if (ctl.acsEn) begin
        for (int i = 0; i < NUM_ST; i++) pmQ[i] <= pmNew[i];
        surv[ctl.col] <= decVec;
      end
      if (ctl.tbEn) begin
        bitBuf[ctl.col] <= curSt[1];                  // input bit that entered curSt
        tbSt <= {curSt[0], surv[ctl.col][curSt]};      // winning predecessor
      end
    end
  end

  assign outBit = bitBuf[ctl.outSel];
endmodule

// File: rtl/viterbi4_dec.sv
module viterbi4_dec
  import v4_pkg::*;
#(
  parameter int WIN = WIN_LEN,
  parameter int PMW = PM_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       symValid,
  input  logic [1:0] sym,
  output logic       busy,
  output logic       outValid,
  output logic       outBit,
  output logic       frameDone
);
  dp_ctrl_t ctl;

  v4_ctrl #(.WIN(WIN)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .symValid(symValid), .ctl(ctl),
    .busy(busy), .outValid(outValid), .frameDone(frameDone)
  );

  v4_dp #(.WIN(WIN), .PMW(PMW)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .sym(sym), .outBit(outBit)
  );
endmodule

// File: rtl/v4_chk.sv
module v4_chk
  import v4_pkg::*;
#(
  parameter int PMW = PM_W
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  busy,
  input logic                  outValid,
  input logic                  frameDone,
  input logic                  acsEn,
  input logic                  useInit,
  input logic [NUM_ST*PMW-1:0] pmFlat
);
  logic [PMW-1:0] minPm;
  always_comb begin
    minPm = pmFlat[PMW-1:0];
    for (int i = 1; i < NUM_ST; i++)
      if (pmFlat[i*PMW +: PMW] < minPm) minPm = pmFlat[i*PMW +: PMW];
  end

  // R8: the end-of-window flag only comes with a decoded bit
  assert_done_in_burst_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frameDone |-> outValid);
  // R8: a burst ends only right after its flagged last bit
  assert_burst_ends_on_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(outValid) |-> $past(frameDone));
  // R9: output is produced only while busy
  assert_out_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> busy);
  // R4: no symbol enters the trellis while busy
  assert_no_take_when_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acsEn |-> !busy);
  // R7: busy starts right after a symbol was taken
  assert_busy_after_symbol_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(acsEn));
  // R3: inside a window the best metric never drops (no wrap)
  assert_min_metric_rises_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acsEn && !useInit) |=> (minPm >= $past(minPm)));
endmodule

bind viterbi4_dec v4_chk #(.PMW(PMW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .outValid(outValid),
  .frameDone(frameDone), .acsEn(ctl.acsEn), .useInit(ctl.useInit),
  .pmFlat(u_dp.pmFlat)
);

// File: tb/sim_viterbi4_dec.sv
module sim_viterbi4_dec;
  localparam int WIN = 7;
  localparam int NV  = 7;
  // {bits (bit i = symbol i), error mask (bits 2i+1:2i on symbol i), expected, tag}
  localparam logic [30:0] VEC [NV] = '{
    {7'b1001101, 14'h0000, 7'b1001101, 3'd0},
    {7'b1111111, 14'h0000, 7'b1111111, 3'd0},
    {7'b0000000, 14'h0000, 7'b0000000, 3'd1},
    {7'b1011010, 14'h0002, 7'b1011010, 3'd2},
    {7'b0010011, 14'h0040, 7'b0010011, 3'd2},
    {7'b0110110, 14'h0800, 7'b0110110, 3'd2},
    {7'b1000000, 14'h1000, 7'b0000000, 3'd3}
  };

  logic clk = 1'b0, rst_n = 1'b0, symValid = 1'b0;
  logic [1:0] sym = '0;
  logic busy, outValid, outBit, frameDone;
  int nChk = 0, nFail = 0;

  always #5 clk = ~clk;

  viterbi4_dec u0 (.clk(clk), .rst_n(rst_n), .symValid(symValid), .sym(sym),
    .busy(busy), .outValid(outValid), .outBit(outBit), .frameDone(frameDone));

  task automatic check(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [13:0] encode(input logic [6:0] bits);
    logic [1:0] s = 2'b00;
    logic [13:0] r = '0;
    for (int i = 0; i < WIN; i++) begin
      r[2*i +: 2] = {bits[i] ^ s[1] ^ s[0], bits[i] ^ s[0]};
      s = {bits[i], s[1]};
    end
    return r;
  endfunction

  // feed one window, then watch busy/output timing and collect the bits
  task automatic run_window(input logic [6:0] bits, input logic [13:0] mask,
                            input logic [6:0] exp, input string tag,
                            input bit gaps, input bit junk);
    logic [13:0] rx = encode(bits) ^ mask;
    logic [6:0] got = '0;
    int firstK = -1, doneK = -1, nOut = 0;
    for (int i = 0; i < WIN; i++) begin
      @(negedge clk); symValid = 1'b1; sym = rx[2*i +: 2];
      if (gaps && i < WIN - 1) begin
        @(negedge clk); symValid = 1'b0; sym = 2'b11;
        @(negedge clk); symValid = 1'b0;
      end
    end
    for (int k = 1; k <= 2 * WIN + 1; k++) begin
      @(negedge clk);
      if (k == 1) check("R7 busy after last symbol", busy, 1);
      if (outValid) begin
        if (firstK < 0) firstK = k;
        if (nOut < WIN) got[nOut] = outBit;
        nOut++;
        if (frameDone) doneK = k;
      end
      if (k == 2 * WIN + 1) check("R9 busy low after burst", busy, 0);
      symValid = junk && (k <= 2 * WIN);
      sym = 2'(k);
    end
    symValid = 1'b0;
    check("R7 output start cycle", firstK, WIN + 1);
    check("R8 burst length", nOut, WIN);
    check("R8 frameDone on last bit", doneK, 2 * WIN);
    nChk++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s decoded actual=%b expected=%b", tag, got, exp);
    end
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", nChk + 1 - nFail, nChk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 busy after reset", busy, 0);
    check("R10 outValid after reset", outValid, 0);
    check("R10 frameDone after reset", frameDone, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 idle before input", busy | outValid, 0);

    // table walk; tags: 0=R1 clean, 1=R5 restart, 2=R2 single error, 3=R6 tie
    for (int v = 0; v < NV; v++) begin
      string tag;
      case (VEC[v][2:0])
        3'd0: tag = "R1 clean window";
        3'd1: tag = "R5 window restart after all-ones";
        3'd2: tag = "R2 single error corrected";
        default: tag = "R6 tie resolves to lowest state";
      endcase
      run_window(VEC[v][30:24], VEC[v][23:10], VEC[v][9:3], tag, 1'b0, 1'b0);
    end

    // R4: idle gaps between symbols
    run_window(7'b0110011, 14'h0, 7'b0110011, "R4 gaps between symbols", 1'b1, 1'b0);
    // R9: junk offered while busy, then a clean window must be unaffected
    run_window(7'b1101001, 14'h0, 7'b1101001, "R9 junk during busy", 1'b0, 1'b1);
    run_window(7'b0011101, 14'h0, 7'b0011101, "R9 window after junk", 1'b0, 1'b0);

    // R10: partial window discarded by reset
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); symValid = 1'b1; sym = 2'b11;
    end
    @(negedge clk); symValid = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    check("R10 busy in reset", busy, 0);
    rst_n = 1'b1;
    run_window(7'b1010110, 14'h0, 7'b1010110, "R10 window after mid-window reset", 1'b0, 1'b0);

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule